// File: doc/BRIEF.md
# Region-Based Memory Security Filter

This block sits in front of a memory or peripheral port and decides, for every transaction, whether it may proceed. A transaction presents an address, a direction, a secure/non-secure flag, an agent ID and the index of the filter port it arrived on. The block compares the address against a set of programmable regions, each with a base and top on 4 KB page granularity. The highest-numbered region that matches and is enabled for that filter port supplies the permissions. Region 0 is fixed to cover the whole address space on every filter port, so every transaction always has a deciding region.

Secure transactions are judged by a two-bit attribute that grants read and write separately. Non-secure transactions are judged by two 16-bit enable maps, one for reads and one for writes, indexed by the low four bits of the agent ID. The decision is registered and appears one cycle after the transaction. A denied write has its memory write strobe suppressed, and denied read data is forced to zero. A programmable two-bit action selects whether a denial also raises a bus error and/or an interrupt line.

A 32-bit register port with a 12-bit byte address programs the regions and the action. Reads return data one cycle after the address is presented.

Top module: `secfilt_top`

## Requirements
- R1: After synchronous reset, every decision output and the config read data are 0. Region 0 grants nothing, so every transaction is denied, and the action is 0.
- R2: Region 0 always matches and reads back base 0, top all ones and a filter mask of all ones. Writes to its base, top or filter-mask fields are ignored. Its secure attribute and ID maps stay writable.
- R3: Writing a base word forces address bits [11:0] to 0, and writing a top word forces them to 1. A region matches when base <= address <= top, with both limits inclusive.
- R4: Attribute bits [NUM_FILTERS-1:0] are a filter mask. A region other than 0 matches only if the mask bit at txn_filter is set.
- R5: When more than one region matches, the highest-numbered one decides. Its number is output on dec_region.
- R6: A secure transaction (txn_nonsec=0) uses attribute bits [31:30] of the deciding region. Bit 30 grants reads and bit 31 grants writes.
- R7: For a non-secure transaction, let n be txn_aid[3:0]. A read is granted by ID-map bit n, and a write is granted by ID-map bit 16+n.
- R8: On a denied transaction, dec_bus_err equals action bit 0 and dec_irq equals action bit 1. On a granted transaction, both are 0.
- R9: dec_wr_en is 1 only for a granted write.
- R10: rd_data_out equals rd_data_in when dec_permit is 1, and is 0 otherwise.
- R11: The decision outputs update on the clock edge after txn_valid. When txn_valid is 0, dec_valid and the decision are 0.
- R12: The config register map is laid out as follows. The action is at byte offset 0x004, bits [1:0]. Region r occupies 0x100+0x20*r. Within that block: +0x00 base low, +0x04 base high, +0x08 top low, +0x0C top high, +0x10 attribute, +0x14 ID map (reads in [15:0], writes in [31:16]). Reads return the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_addr | input | 12 | Config byte address |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data, one cycle after cfg_addr |
| txn_valid | input | 1 | Transaction present |
| txn_addr | input | ADDR_W | Transaction address |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_nonsec | input | 1 | 1 = non-secure transaction |
| txn_aid | input | AID_W | Agent ID (low 4 bits used) |
| txn_filter | input | FI_W | Filter port index |
| rd_data_in | input | DATA_W | Read data from memory |
| dec_valid | output | 1 | Decision present |
| dec_permit | output | 1 | Transaction granted |
| dec_wr_en | output | 1 | Memory write strobe |
| dec_bus_err | output | 1 | Bus error on denial |
| dec_irq | output | 1 | Interrupt on denial |
| dec_region | output | RI_W | Deciding region number |
| rd_data_out | output | DATA_W | Read data after masking |

## Verification
The main sweep crosses addresses on both sides of every page limit with all filter ports, both directions, both security states and four agent IDs. This separates off-by-one limit errors, filter-mask indexing and read/write bit swaps. The nested and overlapping regions make the highest-number rule visible, since a lower-priority choice yields a different region number and different permissions. A region that is set up only on one filter port shows whether the mask is honoured. Repeating the sweep under each action code separates bus-error and interrupt wiring.

// File: rtl/secfilt_pkg.sv
package secfilt_pkg;
  localparam int ACT_OFF    = 'h004;
  localparam int RGN_OFF    = 'h100;
  localparam int RGN_STRIDE = 'h020;

  localparam int FLD_BASE_LO = 0;
  localparam int FLD_BASE_HI = 1;
  localparam int FLD_TOP_LO  = 2;
  localparam int FLD_TOP_HI  = 3;
  localparam int FLD_ATTR    = 4;
  localparam int FLD_IDS     = 5;

  typedef struct packed {
    logic [15:0] wr;
    logic [15:0] rd;
  } id_perm_t;
endpackage

// File: rtl/secfilt_regs.sv
module secfilt_regs
  import secfilt_pkg::*;
#(
  parameter int NUM_REGIONS = 9,
  parameter int ADDR_W      = 40,
  parameter int NUM_FILTERS = 4,
  localparam int PG_W       = ADDR_W - 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_wr,
  input  logic [11:0]            cfg_addr,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  output logic [PG_W-1:0]        base_pg [NUM_REGIONS],
  output logic [PG_W-1:0]        top_pg  [NUM_REGIONS],
  output logic [NUM_FILTERS-1:0] fmask   [NUM_REGIONS],
  output logic [1:0]             sattr   [NUM_REGIONS],
  output id_perm_t               idp     [NUM_REGIONS],
  output logic [1:0]             action
);
  localparam int HI_W = ADDR_W - 32;

  int   roff, rsel, fld;
  logic in_rgn;
  logic [31:0] rd_val;

  always_comb begin
    roff   = int'(cfg_addr) - RGN_OFF;
    rsel   = roff / RGN_STRIDE;
    fld    = (roff % RGN_STRIDE) / 4;
    in_rgn = (int'(cfg_addr) >= RGN_OFF) &&
             (int'(cfg_addr) < RGN_OFF + RGN_STRIDE * NUM_REGIONS);
  end

  always_ff @(posedge clk) begin
    if (rst)                                      action <= '0;
    else if (cfg_wr && int'(cfg_addr) == ACT_OFF) action <= cfg_wdata[1:0];
  end

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
    logic     hit;
    logic [1:0] sa;
    id_perm_t ip;
    assign hit = cfg_wr && in_rgn && (rsel == r);

    always_ff @(posedge clk) begin
      if (rst) begin
        sa <= '0;
        ip <= '0;
      end else if (hit) begin
        if (fld == FLD_ATTR) sa <= cfg_wdata[31:30];
        if (fld == FLD_IDS)  ip <= id_perm_t'(cfg_wdata);
      end
    end
    assign sattr[r] = sa;
    assign idp[r]   = ip;

    if (r == 0) begin : g_fixed
      assign base_pg[r] = '0;
      assign top_pg[r]  = '1;
      assign fmask[r]   = '1;
    end else begin : g_prog
      logic [PG_W-1:0]        b, t;
      logic [NUM_FILTERS-1:0] fm;
      always_ff @(posedge clk) begin
        if (rst) begin
          b  <= '0;
          t  <= '0;
          fm <= '0;
        end else if (hit) begin
          case (fld)
            FLD_BASE_LO: b[19:0]      <= cfg_wdata[31:12];
            FLD_BASE_HI: b[PG_W-1:20] <= cfg_wdata[HI_W-1:0];
            FLD_TOP_LO:  t[19:0]      <= cfg_wdata[31:12];
            FLD_TOP_HI:  t[PG_W-1:20] <= cfg_wdata[HI_W-1:0];
            FLD_ATTR:    fm           <= cfg_wdata[NUM_FILTERS-1:0];
            default: ;
          endcase
        end
      end
      assign base_pg[r] = b;
      assign top_pg[r]  = t;
      assign fmask[r]   = fm;
    end
  end

  always_comb begin
    rd_val = '0;
    if (int'(cfg_addr) == ACT_OFF) begin
      rd_val = {30'b0, action};
    end else if (in_rgn) begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        if (rsel == r) begin
          case (fld)
            FLD_BASE_LO: rd_val = {base_pg[r][19:0], 12'h000};
            FLD_BASE_HI: rd_val = 32'(base_pg[r][PG_W-1:20]);
            FLD_TOP_LO:  rd_val = {top_pg[r][19:0], 12'hFFF};
            FLD_TOP_HI:  rd_val = 32'(top_pg[r][PG_W-1:20]);
            FLD_ATTR:    rd_val = {sattr[r], 30'(fmask[r])};
            FLD_IDS:     rd_val = idp[r];
            default:     rd_val = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_val;
  end

  // R8: the action only changes on a config write
  p_action_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(action));

  // R2: writes leave region 0 limits untouched
  p_region0_top_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (top_pg[0] == '1) && (base_pg[0] == '0));
endmodule

// File: rtl/secfilt_match.sv
module secfilt_match
  import secfilt_pkg::*;
#(
  parameter int NUM_REGIONS = 9,
  parameter int ADDR_W      = 40,
  parameter int NUM_FILTERS = 4,
  parameter int AID_W       = 8,
  localparam int PG_W       = ADDR_W - 12,
  localparam int RI_W       = $clog2(NUM_REGIONS),
  localparam int FI_W       = $clog2(NUM_FILTERS)
) (
  input  logic [PG_W-1:0]        base_pg [NUM_REGIONS],
  input  logic [PG_W-1:0]        top_pg  [NUM_REGIONS],
  input  logic [NUM_FILTERS-1:0] fmask   [NUM_REGIONS],
  input  logic [1:0]             sattr   [NUM_REGIONS],
  input  id_perm_t               idp     [NUM_REGIONS],
  input  logic [ADDR_W-1:0]      txn_addr,
  input  logic                   txn_write,
  input  logic                   txn_nonsec,
  input  logic [AID_W-1:0]       txn_aid,
  input  logic [FI_W-1:0]        txn_filter,
  output logic                   permit,
  output logic [RI_W-1:0]        win
);
  logic [PG_W-1:0] addr_pg;
  logic [3:0]      aid4;
  logic            unused_bits;

  assign addr_pg     = txn_addr[ADDR_W-1:12];
  assign aid4        = txn_aid[3:0];
  assign unused_bits = ^{txn_addr[11:0], txn_aid[AID_W-1:4]};

  // later regions overwrite earlier ones: highest number wins
  always_comb begin
    win = '0;
    for (int r = 1; r < NUM_REGIONS; r++) begin
      if (fmask[r][txn_filter] && addr_pg >= base_pg[r] && addr_pg <= top_pg[r])
        win = RI_W'(r);
    end
  end

  always_comb begin
    if (!txn_nonsec) permit = txn_write ? sattr[win][1] : sattr[win][0];
    else             permit = txn_write ? idp[win].wr[aid4] : idp[win].rd[aid4];
  end
endmodule

// File: rtl/secfilt_top.sv
module secfilt_top
  import secfilt_pkg::*;
#(
  parameter int NUM_REGIONS = 9,
  parameter int ADDR_W      = 40,
  parameter int NUM_FILTERS = 4,
  parameter int AID_W       = 8,
  parameter int DATA_W      = 32,
  localparam int RI_W       = $clog2(NUM_REGIONS),
  localparam int FI_W       = $clog2(NUM_FILTERS),
  localparam int PG_W       = ADDR_W - 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [11:0]       cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              txn_valid,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              txn_write,
  input  logic              txn_nonsec,
  input  logic [AID_W-1:0]  txn_aid,
  input  logic [FI_W-1:0]   txn_filter,
  input  logic [DATA_W-1:0] rd_data_in,
  output logic              dec_valid,
  output logic              dec_permit,
  output logic              dec_wr_en,
  output logic              dec_bus_err,
  output logic              dec_irq,
  output logic [RI_W-1:0]   dec_region,
  output logic [DATA_W-1:0] rd_data_out
);
  logic [PG_W-1:0]        base_pg [NUM_REGIONS];
  logic [PG_W-1:0]        top_pg  [NUM_REGIONS];
  logic [NUM_FILTERS-1:0] fmask   [NUM_REGIONS];
  logic [1:0]             sattr   [NUM_REGIONS];
  id_perm_t               idp     [NUM_REGIONS];
  logic [1:0]             action;
  logic                   ok;
  logic [RI_W-1:0]        win;

  secfilt_regs #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .NUM_FILTERS(NUM_FILTERS)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .base_pg(base_pg), .top_pg(top_pg), .fmask(fmask),
    .sattr(sattr), .idp(idp), .action(action));

  secfilt_match #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .NUM_FILTERS(NUM_FILTERS),
                  .AID_W(AID_W)) u_match (
    .base_pg(base_pg), .top_pg(top_pg), .fmask(fmask), .sattr(sattr), .idp(idp),
    .txn_addr(txn_addr), .txn_write(txn_write), .txn_nonsec(txn_nonsec),
    .txn_aid(txn_aid), .txn_filter(txn_filter), .permit(ok), .win(win));

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid   <= 1'b0;
      dec_permit  <= 1'b0;
      dec_wr_en   <= 1'b0;
      dec_bus_err <= 1'b0;
      dec_irq     <= 1'b0;
      dec_region  <= '0;
    end else begin
      dec_valid   <= txn_valid;
      dec_permit  <= txn_valid && ok;
      dec_wr_en   <= txn_valid && ok && txn_write;
      dec_bus_err <= txn_valid && !ok && action[0];
      dec_irq     <= txn_valid && !ok && action[1];
      dec_region  <= txn_valid ? win : '0;
    end
  end

  assign rd_data_out = dec_permit ? rd_data_in : '0;

  p_wr_needs_permit_r9: assert property (@(posedge clk) disable iff (rst)
    dec_wr_en |-> dec_permit && dec_valid);

  p_err_only_on_deny_r8: assert property (@(posedge clk) disable iff (rst)
    (dec_bus_err || dec_irq) |-> dec_valid && !dec_permit);

  p_valid_latency_r11: assert property (@(posedge clk) disable iff (rst)
    txn_valid |=> dec_valid);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !txn_valid |=> !dec_valid && !dec_permit && !dec_wr_en);

  p_deny_zero_data_r10: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_permit) |-> (rd_data_out == '0));
endmodule

// File: tb/sim_secfilt_top.sv
`timescale 1ns/1ps
module sim_secfilt_top;
  localparam int NR = 9;
  localparam int AW = 40;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr;
  logic [11:0] cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        txn_valid, txn_write, txn_nonsec;
  logic [AW-1:0] txn_addr;
  logic [7:0]  txn_aid;
  logic [1:0]  txn_filter;
  logic [31:0] rd_data_in, rd_data_out;
  logic        dec_valid, dec_permit, dec_wr_en, dec_bus_err, dec_irq;
  logic [3:0]  dec_region;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [AW-1:0] m_base [NR];
  logic [AW-1:0] m_top  [NR];
  logic [3:0]    m_fm   [NR];
  logic [1:0]    m_sa   [NR];
  logic [31:0]   m_id   [NR];
  logic [1:0]    m_act;

  always #10 clk = ~clk;

  secfilt_top u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .txn_valid(txn_valid), .txn_addr(txn_addr), .txn_write(txn_write),
    .txn_nonsec(txn_nonsec), .txn_aid(txn_aid), .txn_filter(txn_filter),
    .rd_data_in(rd_data_in), .dec_valid(dec_valid), .dec_permit(dec_permit),
    .dec_wr_en(dec_wr_en), .dec_bus_err(dec_bus_err), .dec_irq(dec_irq),
    .dec_region(dec_region), .rd_data_out(rd_data_out));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 12'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input int a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = 12'(a);
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic set_region(input int r, input logic [AW-1:0] b, input logic [AW-1:0] t,
                            input logic [3:0] fm, input logic [1:0] sa, input logic [31:0] id);
    int o;
    o = 'h100 + 'h20 * r;
    cfg_write(o + 'h00, b[31:0]);
    cfg_write(o + 'h04, 32'(b[AW-1:32]));
    cfg_write(o + 'h08, t[31:0]);
    cfg_write(o + 'h0C, 32'(t[AW-1:32]));
    cfg_write(o + 'h10, {sa, 26'b0, fm});
    cfg_write(o + 'h14, id);
    if (r != 0) begin
      m_base[r] = {b[AW-1:12], 12'h000};
      m_top[r]  = {t[AW-1:12], 12'hFFF};
      m_fm[r]   = fm;
    end
    m_sa[r] = sa;
    m_id[r] = id;
  endtask

  task automatic run_txn(input logic [AW-1:0] a, input int f, input bit w, input bit ns,
                         input logic [7:0] aid);
    int  wr_idx;
    bit  ok;
    int  n;
    @(negedge clk);
    txn_valid = 1'b1; txn_addr = a; txn_filter = 2'(f);
    txn_write = w; txn_nonsec = ns; txn_aid = aid;
    @(negedge clk);
    wr_idx = 0;
    for (int r = 1; r < NR; r++)
      if (m_fm[r][f] && a >= m_base[r] && a <= m_top[r]) wr_idx = r;
    n = int'(aid[3:0]);
    if (!ns) ok = w ? m_sa[wr_idx][1] : m_sa[wr_idx][0];
    else     ok = w ? m_id[wr_idx][16+n] : m_id[wr_idx][n];
    chk("R11 decision valid", 64'(dec_valid), 64'd1);
    chk("R4 R5 deciding region", 64'(dec_region), 64'(wr_idx));
    chk(ns ? "R7 nonsecure permit" : "R6 secure permit", 64'(dec_permit), 64'(ok));
    chk("R9 write strobe", 64'(dec_wr_en), 64'(ok && w));
    chk("R8 denial action", 64'({dec_bus_err, dec_irq}),
        64'(ok ? 2'b00 : {m_act[0], m_act[1]}));
    chk("R10 read data", 64'(rd_data_out), ok ? 64'(rd_data_in) : 64'd0);
    txn_valid = 1'b0;
  endtask

  task automatic sweep(input int fmax);
    logic [AW-1:0] addrs [13];
    logic [7:0]    aids  [4];
    addrs = '{40'h0, 40'hFFF, 40'h1000, 40'h2FFF, 40'h3000, 40'h3FFF, 40'h4000,
              40'h4FFF, 40'h5000, 40'h80_0000_0000, 40'h80_0000_0FFF,
              40'h80_0000_1000, 40'hFF_FFFF_FFFF};
    aids  = '{8'h01, 8'h02, 8'h13, 8'h25};
    for (int i = 0; i < 13; i++)
      for (int f = 0; f < fmax; f++)
        for (int w = 0; w < 2; w++)
          for (int ns = 0; ns < 2; ns++)
            for (int k = 0; k < 4; k++)
              run_txn(addrs[i], f, w[0], ns[0], aids[k]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int r = 0; r < NR; r++) begin
      m_base[r] = '0; m_top[r] = '0; m_fm[r] = '0; m_sa[r] = '0; m_id[r] = '0;
    end
    m_top[0] = '1; m_fm[0] = 4'hF; m_act = 2'b00;
    rst = 1'b1; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    txn_valid = 1'b0; txn_addr = '0; txn_write = 1'b0; txn_nonsec = 1'b0;
    txn_aid = '0; txn_filter = '0; rd_data_in = 32'hC0DE_1234;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 reset outputs", 64'({dec_valid, dec_permit, dec_wr_en, dec_bus_err, dec_irq, dec_region}), 64'd0);
    chk("R1 reset rdata", 64'(cfg_rdata), 64'd0);
    cfg_read('h004, d);
    chk("R1 reset action", 64'(d), 64'd0);
    run_txn(40'h2000, 0, 1'b0, 1'b0, 8'h00);
    chk("R1 reset denies", 64'(dec_permit), 64'd0);

    // R11: idle cycle gives no decision
    @(negedge clk);
    chk("R11 idle", 64'({dec_valid, dec_permit}), 64'd0);

    // R2: region 0 fixed limits
    cfg_read('h108, d); chk("R2 region0 top low", 64'(d), 64'hFFFF_FFFF);
    cfg_read('h10C, d); chk("R2 region0 top high", 64'(d), 64'hFF);
    cfg_read('h110, d); chk("R2 region0 mask", 64'(d), 64'hF);
    cfg_write('h100, 32'h1234_5000);
    cfg_write('h108, 32'h0000_0FFF);
    cfg_write('h110, 32'h0000_0000);
    cfg_read('h100, d); chk("R2 region0 base ignored", 64'(d), 64'd0);
    cfg_read('h108, d); chk("R2 region0 top ignored", 64'(d), 64'hFFFF_FFFF);
    cfg_read('h110, d); chk("R2 region0 mask ignored", 64'(d), 64'hF);
    run_txn(40'h7000_0000, 3, 1'b0, 1'b0, 8'h00);
    chk("R2 region0 still covers", 64'(dec_region), 64'd0);

    // regions
    set_region(0, 40'h0, 40'h0, 4'h0, 2'b11, 32'h0008_000A);
    set_region(1, 40'h1000, 40'h4FFF, 4'h1, 2'b01, 32'h0000_0004);
    set_region(2, 40'h3ABC, 40'h3123, 4'h3, 2'b10, 32'h0020_0000);
    set_region(8, 40'h80_0000_0000, 40'h80_0000_0000, 4'h4, 2'b11, 32'hFFFF_FFFF);

    // R3: alignment forcing on readback
    cfg_read('h140, d); chk("R3 base aligned", 64'(d), 64'h3000);
    cfg_read('h148, d); chk("R3 top aligned", 64'(d), 64'h3FFF);
    cfg_read('h204, d); chk("R12 base high", 64'(d), 64'h80);
    // R12: attribute, ID map and action readback
    cfg_read('h130, d); chk("R12 attribute", 64'(d), 64'h4000_0001);
    cfg_read('h154, d); chk("R12 id map", 64'(d), 64'h0020_0000);
    cfg_write('h004, 32'h1); m_act = 2'b01;
    cfg_read('h004, d); chk("R12 action", 64'(d), 64'h1);

    // R4: region 2 is not enabled on filter 2, region 1 not on filter 1
    run_txn(40'h3000, 2, 1'b1, 1'b0, 8'h00);
    chk("R4 filter mask off", 64'(dec_region), 64'd0);
    run_txn(40'h1000, 1, 1'b0, 1'b0, 8'h00);
    chk("R4 filter mask off r1", 64'(dec_region), 64'd0);
    // R5: nested region 2 over region 1
    run_txn(40'h3800, 0, 1'b0, 1'b0, 8'h00);
    chk("R5 nested priority", 64'(dec_region), 64'd2);

    sweep(4);
    cfg_write('h004, 32'h2); m_act = 2'b10;
    sweep(1);
    cfg_write('h004, 32'h3); m_act = 2'b11;
    sweep(1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule